// File: doc/BRIEF.md
# Inquire Snoop Responder for Split Instruction and Data Caches

The block answers coherency inquiries that system logic drives after it has taken the address bus. While the bus-grant input is high, an inquire strobe carries a physical address and an invalidate flag. The block looks the address up in the physical tag arrays of both the instruction cache and the data cache. It reports a clean hit and a modified hit on two separate outputs and moves the matching lines to their new states. The data cache keeps a four-state line state; the instruction cache keeps one valid bit per line.

If an invalidating inquiry finds a modified data line, the block raises a writeback request with the line address and holds it until the system acknowledges. The line is invalidated only after that acknowledge. The core fills and updates both tag arrays through a write port that is accepted in every cycle and never stalls. When the core and the snoop logic write the same line in the same cycle, the snoop write wins. The default geometry is 32-bit addresses, 32-byte lines, 64 sets and 2 ways in each cache.

Top module: `inq_snoop_unit`

## Requirements
- R1: While reset is asserted, every line in both caches becomes invalid and `hit_clean`, `hit_mod`, `inq_err` and `wb_req` are all low.
- R2: An inquire strobe has an effect only when `hold_grant` is high in the same cycle. Without `hold_grant` it changes no output and no line state.
- R3: `hit_clean` goes high when the inquired line is valid in either way of the instruction cache, or is in state shared (01) or exclusive (10) in either way of the data cache.
- R4: `hit_mod` goes high when the inquired line is in state modified (11) in a data cache way. State code 00 means invalid.
- R5: If a strobe is accepted at clock edge n, both hit outputs take their new values at edge n+1. They then hold until the next accepted inquiry completes its lookup.
- R6: With `inq_inval` low, a hit data line in the exclusive or modified state becomes shared at edge n+1. A hit shared data line and a hit instruction line stay valid.
- R7: With `inq_inval` high, every hit line that is not modified becomes invalid at edge n+1. A modified data hit raises `wb_req` at edge n+1, with `wb_addr` = {tag, index, five zero offset bits}. `wb_req` and `wb_addr` hold steady until `wb_ack` is sampled high. At that edge `wb_req` drops and the line becomes invalid.
- R8: A strobe with `hold_grant` high that arrives while the previous inquiry is still in its lookup cycle, or while `wb_req` is high, is ignored. `inq_err` is then high for exactly the one cycle after that edge.
- R9: A core write is accepted in every cycle. It writes the tag and the state code of the selected way in the data cache (`core_wr_dc`=1) or the instruction cache (`core_wr_dc`=0). In the instruction cache, any nonzero code means valid. A write at edge n is seen by an inquiry whose strobe is sampled at edge n or later.
- R10: When a snoop state write and a core write target the same cache, set and way at the same edge, the line ends in the snoop's state while keeping the core's tag.
- R11: Both ways of the indexed set are compared, and the byte-offset bits of the inquire address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_grant | input | 1 | System logic owns the address bus |
| inq_strobe | input | 1 | Inquire address strobe |
| inq_inval | input | 1 | Invalidate on hit |
| inq_addr | input | ADDR_W (32) | Inquire physical address |
| hit_clean | output | 1 | Clean hit in either cache |
| hit_mod | output | 1 | Modified hit in the data cache |
| inq_err | output | 1 | Strobe rejected while busy |
| wb_req | output | 1 | Writeback request |
| wb_addr | output | ADDR_W (32) | Line address of the writeback |
| wb_ack | input | 1 | Writeback accepted |
| core_wr_en | input | 1 | Core tag/state write enable |
| core_wr_dc | input | 1 | 1 selects the data cache, 0 the instruction cache |
| core_wr_addr | input | ADDR_W (32) | Address that supplies the written tag and set index |
| core_wr_way | input | $clog2(WAYS) (1) | Way written |
| core_wr_state | input | 2 | State code written |

## Verification
A wrong line state stays hidden until the next inquiry that reaches that line. It then shows on `hit_clean` or `hit_mod` one edge after that strobe is sampled. A lost or duplicate writeback shows at once on `wb_req` or `wb_addr`. The reference model follows every line of both caches edge by edge, including core-versus-snoop collisions. The directed tests re-inquire a line after each transition, so a bad transition appears within a few cycles. A long randomized phase with a small set of tags and sets keeps lines colliding, so stale state is exposed soon after it is created.

// File: rtl/inq_snoop_pkg.sv
package inq_snoop_pkg;

   // Line state codes shared by both tag arrays (instruction side uses 00/01 only).
   typedef enum logic [1:0] {
      LN_INV = 2'b00,
      LN_SHR = 2'b01,
      LN_EXC = 2'b10,
      LN_MOD = 2'b11
   } line_st_e;

   // Target state written by the snoop for a non-modified hit line.
   function automatic line_st_e snoop_target(input logic inval);
      return inval ? LN_INV : LN_SHR;
   endfunction

   // Line presence test used by both arrays.
   function automatic logic st_live(input logic [1:0] st);
      return st != LN_INV;
   endfunction

endpackage

// File: rtl/inq_tag_array.sv
module inq_tag_array
   import inq_snoop_pkg::*;
#(
   parameter int TAG_W      = 21,
   parameter int IDX_W      = 6,
   parameter int WAYS       = 2,
   parameter bit FULL_STATE = 1'b1,
   localparam int SETS      = 1 << IDX_W,
   localparam int WAY_W     = $clog2(WAYS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   // lookup read port
   input  logic [IDX_W-1:0]              rd_idx,
   output logic [WAYS-1:0][TAG_W-1:0]    rd_tag,
   output logic [WAYS-1:0][1:0]          rd_st,
   // core write port: tag and state
   input  logic                          cw_en,
   input  logic [IDX_W-1:0]              cw_idx,
   input  logic [WAY_W-1:0]              cw_way,
   input  logic [TAG_W-1:0]              cw_tag,
   input  logic [1:0]                    cw_st,
   // snoop write port: state only, wins over the core port (R10)
   input  logic                          sw_en,
   input  logic [IDX_W-1:0]              sw_idx,
   input  logic [WAYS-1:0]               sw_mask,
   input  logic [1:0]                    sw_st
);

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      localparam logic [WAY_W-1:0] WID = WAY_W'(w);

      logic [TAG_W-1:0] tag_q [SETS];
      logic             cw_hit;
      logic             sw_hit;

      assign cw_hit = cw_en && (cw_way == WID);
      assign sw_hit = sw_en && sw_mask[w];

      always_ff @(posedge clk) begin
         if (cw_hit) tag_q[cw_idx] <= cw_tag;
      end

      assign rd_tag[w] = tag_q[rd_idx];

      if (FULL_STATE) begin : g_mesi
         logic [1:0] st_q [SETS];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < SETS; s++) st_q[s] <= LN_INV;
            end else begin
               if (cw_hit) st_q[cw_idx] <= cw_st;
               // later assignment wins: snoop priority
               if (sw_hit) st_q[sw_idx] <= sw_st;
            end
         end

         assign rd_st[w] = st_q[rd_idx];
      end else begin : g_valid
         logic vld_q [SETS];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < SETS; s++) vld_q[s] <= 1'b0;
            end else begin
               if (cw_hit) vld_q[cw_idx] <= st_live(cw_st);
               if (sw_hit) vld_q[sw_idx] <= st_live(sw_st);
            end
         end

         assign rd_st[w] = vld_q[rd_idx] ? LN_SHR : LN_INV;
      end
   end

endmodule

// File: rtl/inq_way_match.sv
module inq_way_match
   import inq_snoop_pkg::*;
#(
   parameter int TAG_W  = 21,
   parameter int WAYS   = 2,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [TAG_W-1:0]              key,
   input  logic [WAYS-1:0][TAG_W-1:0]    tags,
   input  logic [WAYS-1:0][1:0]          sts,
   output logic [WAYS-1:0]               hit_vec,
   output logic [WAYS-1:0]               mod_vec,
   output logic                          any_clean,
   output logic                          any_mod,
   output logic [WAY_W-1:0]              mod_way
);

   logic [WAYS-1:0] clean_vec;

   // R11: every way of the indexed set is compared in parallel
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      logic tag_eq;
      assign tag_eq       = (tags[w] == key);
      assign hit_vec[w]   = tag_eq && st_live(sts[w]);
      assign mod_vec[w]   = hit_vec[w] && (sts[w] == LN_MOD);
      assign clean_vec[w] = hit_vec[w] && (sts[w] != LN_MOD);
   end

   assign any_clean = |clean_vec;
   assign any_mod   = |mod_vec;

   // lowest-numbered modified way is the writeback candidate
   always_comb begin
      mod_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (mod_vec[w]) mod_way = WAY_W'(w);
      end
   end

endmodule

// File: rtl/inq_wb_ctrl.sv
module inq_wb_ctrl #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 6,
   parameter int WAY_W  = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ADDR_W-1:0]  start_addr,
   input  logic [IDX_W-1:0]   start_idx,
   input  logic [WAY_W-1:0]   start_way,
   input  logic               wb_ack,
   output logic               wb_req,
   output logic [ADDR_W-1:0]  wb_addr,
   output logic               done,
   output logic [IDX_W-1:0]   done_idx,
   output logic [WAY_W-1:0]   done_way
);

   logic [IDX_W-1:0] pend_idx;
   logic [WAY_W-1:0] pend_way;

   // R7: request held with a frozen address until acknowledged
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_req   <= 1'b0;
         wb_addr  <= '0;
         pend_idx <= '0;
         pend_way <= '0;
      end else if (wb_req) begin
         if (wb_ack) wb_req <= 1'b0;
      end else if (start) begin
         wb_req   <= 1'b1;
         wb_addr  <= start_addr;
         pend_idx <= start_idx;
         pend_way <= start_way;
      end
   end

   assign done     = wb_req && wb_ack;
   assign done_idx = pend_idx;
   assign done_way = pend_way;

endmodule

// File: rtl/inq_snoop_unit.sv
module inq_snoop_unit
   import inq_snoop_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int SETS       = 64,
   parameter int WAYS       = 2,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int IDX_W     = $clog2(SETS),
   localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
   localparam int WAY_W     = $clog2(WAYS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hold_grant,
   input  logic               inq_strobe,
   input  logic               inq_inval,
   input  logic [ADDR_W-1:0]  inq_addr,
   output logic               hit_clean,
   output logic               hit_mod,
   output logic               inq_err,
   output logic               wb_req,
   output logic [ADDR_W-1:0]  wb_addr,
   input  logic               wb_ack,
   input  logic               core_wr_en,
   input  logic               core_wr_dc,
   input  logic [ADDR_W-1:0]  core_wr_addr,
   input  logic [WAY_W-1:0]   core_wr_way,
   input  logic [1:0]         core_wr_state
);

   // ---------------- elaboration checks ----------------
   if (LINE_BYTES < 4 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_chk_line
      $error("LINE_BYTES must be a power of two of at least 4");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_chk_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_chk_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_chk_tag
      $error("ADDR_W leaves no tag bits");
   end

   // ---------------- inquiry acceptance (R2, R8) ----------------
   logic               s1_v;
   logic               s1_inval;
   logic [TAG_W-1:0]   s1_tag;
   logic [IDX_W-1:0]   s1_idx;
   logic               busy;
   logic               qualified;
   logic               accept;

   assign busy      = s1_v || wb_req;
   assign qualified = hold_grant && inq_strobe;
   assign accept    = qualified && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v     <= 1'b0;
         s1_inval <= 1'b0;
         s1_tag   <= '0;
         s1_idx   <= '0;
         inq_err  <= 1'b0;
      end else begin
         s1_v    <= accept;
         inq_err <= qualified && busy;
         if (accept) begin
            s1_inval <= inq_inval;
            s1_tag   <= inq_addr[ADDR_W-1 -: TAG_W];
            s1_idx   <= inq_addr[OFF_W +: IDX_W];
         end
      end
   end

   // offset bits carry no meaning for tags (R11)
   logic unused_offsets;
   assign unused_offsets = ^{inq_addr[OFF_W-1:0], core_wr_addr[OFF_W-1:0]};

   // ---------------- core write decode (R9) ----------------
   logic [TAG_W-1:0] cw_tag;
   logic [IDX_W-1:0] cw_idx;
   logic             ic_cw_en;
   logic             dc_cw_en;

   assign cw_tag   = core_wr_addr[ADDR_W-1 -: TAG_W];
   assign cw_idx   = core_wr_addr[OFF_W +: IDX_W];
   assign ic_cw_en = core_wr_en && !core_wr_dc;
   assign dc_cw_en = core_wr_en &&  core_wr_dc;

   // ---------------- tag arrays ----------------
   logic [WAYS-1:0][TAG_W-1:0] ic_tag;
   logic [WAYS-1:0][1:0]       ic_st;
   logic [WAYS-1:0][TAG_W-1:0] dc_tag;
   logic [WAYS-1:0][1:0]       dc_st;

   logic                       ic_sw_en;
   logic [WAYS-1:0]            ic_sw_mask;
   logic                       dc_sw_en;
   logic [IDX_W-1:0]           dc_sw_idx;
   logic [WAYS-1:0]            dc_sw_mask;
   line_st_e                   dc_sw_st;

   inq_tag_array #(
      .TAG_W(TAG_W), .IDX_W(IDX_W), .WAYS(WAYS), .FULL_STATE(1'b0)
   ) u_ic_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (s1_idx),
      .rd_tag  (ic_tag),
      .rd_st   (ic_st),
      .cw_en   (ic_cw_en),
      .cw_idx  (cw_idx),
      .cw_way  (core_wr_way),
      .cw_tag  (cw_tag),
      .cw_st   (core_wr_state),
      .sw_en   (ic_sw_en),
      .sw_idx  (s1_idx),
      .sw_mask (ic_sw_mask),
      .sw_st   (LN_INV)
   );

   inq_tag_array #(
      .TAG_W(TAG_W), .IDX_W(IDX_W), .WAYS(WAYS), .FULL_STATE(1'b1)
   ) u_dc_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (s1_idx),
      .rd_tag  (dc_tag),
      .rd_st   (dc_st),
      .cw_en   (dc_cw_en),
      .cw_idx  (cw_idx),
      .cw_way  (core_wr_way),
      .cw_tag  (cw_tag),
      .cw_st   (core_wr_state),
      .sw_en   (dc_sw_en),
      .sw_idx  (dc_sw_idx),
      .sw_mask (dc_sw_mask),
      .sw_st   (dc_sw_st)
   );

   // ---------------- lookup (R3, R4) ----------------
   logic [WAYS-1:0]  ic_hit_vec;
   logic [WAYS-1:0]  ic_mod_unused;
   logic             ic_any_clean;
   logic             ic_any_mod_unused;
   logic [WAY_W-1:0] ic_mod_way_unused;

   logic [WAYS-1:0]  dc_hit_vec;
   logic [WAYS-1:0]  dc_mod_vec;
   logic             dc_any_clean;
   logic             dc_any_mod;
   logic [WAY_W-1:0] dc_mod_way;

   inq_way_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_ic_match (
      .key       (s1_tag),
      .tags      (ic_tag),
      .sts       (ic_st),
      .hit_vec   (ic_hit_vec),
      .mod_vec   (ic_mod_unused),
      .any_clean (ic_any_clean),
      .any_mod   (ic_any_mod_unused),
      .mod_way   (ic_mod_way_unused)
   );

   inq_way_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_dc_match (
      .key       (s1_tag),
      .tags      (dc_tag),
      .sts       (dc_st),
      .hit_vec   (dc_hit_vec),
      .mod_vec   (dc_mod_vec),
      .any_clean (dc_any_clean),
      .any_mod   (dc_any_mod),
      .mod_way   (dc_mod_way)
   );

   // R5: results registered one edge after acceptance, held otherwise
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_clean <= 1'b0;
         hit_mod   <= 1'b0;
      end else if (s1_v) begin
         hit_clean <= ic_any_clean || dc_any_clean;
         hit_mod   <= dc_any_mod;
      end
   end

   // ---------------- writeback path (R7) ----------------
   logic             wb_start;
   logic [ADDR_W-1:0] wb_line_addr;
   logic             wb_done;
   logic [IDX_W-1:0] wb_done_idx;
   logic [WAY_W-1:0] wb_done_way;

   assign wb_start     = s1_v && s1_inval && dc_any_mod;
   assign wb_line_addr = {s1_tag, s1_idx, {OFF_W{1'b0}}};

   inq_wb_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_wb (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (wb_start),
      .start_addr (wb_line_addr),
      .start_idx  (s1_idx),
      .start_way  (dc_mod_way),
      .wb_ack     (wb_ack),
      .wb_req     (wb_req),
      .wb_addr    (wb_addr),
      .done       (wb_done),
      .done_idx   (wb_done_idx),
      .done_way   (wb_done_way)
   );

   // ---------------- snoop state writes (R6, R7, R10) ----------------
   assign ic_sw_en   = s1_v && s1_inval && (|ic_hit_vec);
   assign ic_sw_mask = ic_hit_vec;

   always_comb begin
      dc_sw_en   = 1'b0;
      dc_sw_idx  = s1_idx;
      dc_sw_mask = '0;
      dc_sw_st   = LN_INV;
      if (wb_done) begin
         dc_sw_en   = 1'b1;
         dc_sw_idx  = wb_done_idx;
         dc_sw_mask = WAYS'(1) << wb_done_way;
      end else if (s1_v) begin
         dc_sw_en   = |dc_hit_vec;
         dc_sw_mask = s1_inval ? (dc_hit_vec & ~dc_mod_vec) : dc_hit_vec;
         dc_sw_st   = snoop_target(s1_inval);
      end
   end

endmodule

// File: rtl/inq_snoop_chk.sv
module inq_snoop_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hold_grant,
   input logic              inq_strobe,
   input logic              hit_clean,
   input logic              hit_mod,
   input logic              inq_err,
   input logic              wb_req,
   input logic [ADDR_W-1:0] wb_addr,
   input logic              wb_ack
);

   // R1: outputs quiet while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (!hit_clean && !hit_mod && !inq_err && !wb_req);
      end
   end

   // R2: no bus grant, no rejection flag
   p_no_grant_no_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_grant |=> !inq_err);

   // R7: request persists with a stable address until acknowledged
   p_wb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr)));

   // R7: acknowledge ends the request
   p_wb_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_req && wb_ack) |=> !wb_req);

   // R7/R4: a new writeback always comes with a modified-hit report
   p_wb_with_mod_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wb_req) |-> hit_mod);

   // R8: a granted strobe during a pending writeback is flagged
   p_busy_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_grant && inq_strobe && wb_req) |=> inq_err);

endmodule

bind inq_snoop_unit inq_snoop_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hold_grant (hold_grant),
   .inq_strobe (inq_strobe),
   .hit_clean  (hit_clean),
   .hit_mod    (hit_mod),
   .inq_err    (inq_err),
   .wb_req     (wb_req),
   .wb_addr    (wb_addr),
   .wb_ack     (wb_ack)
);

// File: tb/inq_snoop_unit_test.sv
module inq_snoop_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic        hold_grant = 1'b0;
   logic        inq_strobe = 1'b0;
   logic        inq_inval = 1'b0;
   logic [31:0] inq_addr = '0;
   logic        wb_ack = 1'b0;
   logic        core_wr_en = 1'b0;
   logic        core_wr_dc = 1'b0;
   logic [31:0] core_wr_addr = '0;
   logic [0:0]  core_wr_way = '0;
   logic [1:0]  core_wr_state = '0;
   logic        hit_clean, hit_mod, inq_err, wb_req;
   logic [31:0] wb_addr;

   always #4 clk = ~clk;   // 125 MHz

   inq_snoop_unit uut (
      .clk(clk), .rst_n(rst_n), .hold_grant(hold_grant), .inq_strobe(inq_strobe),
      .inq_inval(inq_inval), .inq_addr(inq_addr), .hit_clean(hit_clean),
      .hit_mod(hit_mod), .inq_err(inq_err), .wb_req(wb_req), .wb_addr(wb_addr),
      .wb_ack(wb_ack), .core_wr_en(core_wr_en), .core_wr_dc(core_wr_dc),
      .core_wr_addr(core_wr_addr), .core_wr_way(core_wr_way),
      .core_wr_state(core_wr_state)
   );

   // ---------------- behavioural reference model ----------------
   int m_dtag [2][64];
   int m_dst  [2][64];
   int m_itag [2][64];
   int m_iv   [2][64];
   bit m_s1v, m_s1inv;
   int m_s1tag, m_s1idx;
   bit e_clean, e_mod, e_err, e_wbreq;
   logic [31:0] e_wbaddr;
   int e_wbidx, e_wbway;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   function automatic logic [31:0] mk(int tag, int idx, int off = 0);
      return (32'(tag) << 11) | (32'(idx & 63) << 5) | 32'(off & 31);
   endfunction

   task automatic model_reset();
      for (int w = 0; w < 2; w++)
         for (int s = 0; s < 64; s++) begin
            m_dst[w][s] = 0;
            m_iv[w][s]  = 0;
         end
      m_s1v = 0; e_clean = 0; e_mod = 0; e_err = 0; e_wbreq = 0;
   endtask

   task automatic model_step();
      bit busy, acc, nerr, wdone;
      bit ih [2];
      bit dh [2];
      bit dm [2];
      int mw, ci, ct, cw;
      busy  = m_s1v || e_wbreq;
      acc   = hold_grant && inq_strobe && !busy;
      nerr  = hold_grant && inq_strobe && busy;
      wdone = e_wbreq && wb_ack;
      mw = -1;
      // lookup uses the state before this edge (R3, R4, R11)
      if (m_s1v) begin
         bit cl = 0, md = 0;
         for (int w = 0; w < 2; w++) begin
            ih[w] = (m_iv[w][m_s1idx] != 0) && (m_itag[w][m_s1idx] == m_s1tag);
            dh[w] = (m_dst[w][m_s1idx] != 0) && (m_dtag[w][m_s1idx] == m_s1tag);
            dm[w] = dh[w] && (m_dst[w][m_s1idx] == 3);
            if (ih[w] || (dh[w] && !dm[w])) cl = 1;
            if (dm[w]) begin
               md = 1;
               if (mw < 0) mw = w;
            end
         end
         e_clean = cl;
         e_mod   = md;
      end
      // core write first (R9)
      if (core_wr_en) begin
         ci = int'(core_wr_addr[10:5]);
         ct = int'(core_wr_addr[31:11]);
         cw = int'(core_wr_way);
         if (core_wr_dc) begin
            m_dtag[cw][ci] = ct;
            m_dst[cw][ci]  = int'(core_wr_state);
         end else begin
            m_itag[cw][ci] = ct;
            m_iv[cw][ci]   = (core_wr_state != 0) ? 1 : 0;
         end
      end
      // snoop writes override (R10)
      if (wdone) begin
         m_dst[e_wbway][e_wbidx] = 0;
         e_wbreq = 0;
      end
      if (m_s1v) begin
         for (int w = 0; w < 2; w++) begin
            if (m_s1inv) begin
               if (ih[w]) m_iv[w][m_s1idx] = 0;
               if (dh[w] && !dm[w]) m_dst[w][m_s1idx] = 0;
            end else if (dh[w]) begin
               m_dst[w][m_s1idx] = 1;
            end
         end
         if (m_s1inv && mw >= 0) begin
            e_wbreq  = 1;
            e_wbaddr = mk(m_s1tag, m_s1idx);
            e_wbidx  = m_s1idx;
            e_wbway  = mw;
         end
      end
      e_err = nerr;
      m_s1v = acc;
      if (acc) begin
         m_s1inv = inq_inval;
         m_s1tag = int'(inq_addr[31:11]);
         m_s1idx = int'(inq_addr[10:5]);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else        model_step();
   end

   // ---------------- comparison away from the active edge ----------------
   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0h expected %0h", what, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!finished) begin
         if (!rst_n) begin
            chk("R1 hit_clean in reset", 32'(hit_clean), 0);
            chk("R1 hit_mod in reset",   32'(hit_mod),   0);
            chk("R1 wb_req in reset",    32'(wb_req),    0);
            chk("R1 inq_err in reset",   32'(inq_err),   0);
         end else begin
            chk("R3/R5 hit_clean", 32'(hit_clean), 32'(e_clean));
            chk("R4/R5 hit_mod",   32'(hit_mod),   32'(e_mod));
            chk("R8 inq_err",      32'(inq_err),   32'(e_err));
            chk("R7 wb_req",       32'(wb_req),    32'(e_wbreq));
            if (e_wbreq) chk("R7 wb_addr", wb_addr, e_wbaddr);
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic fill(bit dc, int tag, int idx, bit way, int st);
      core_wr_en    = 1'b1;
      core_wr_dc    = dc;
      core_wr_addr  = mk(tag, idx);
      core_wr_way   = way;
      core_wr_state = 2'(st);
      tick();
      core_wr_en = 1'b0;
   endtask

   task automatic inquire(int tag, int idx, bit inv, int off = 0);
      inq_strobe = 1'b1;
      inq_inval  = inv;
      inq_addr   = mk(tag, idx, off);
      tick();
      inq_strobe = 1'b0;
      tick(3);
   endtask

   task automatic ack_wb(int wait_cycles);
      tick(wait_cycles);
      wb_ack = 1'b1;
      tick();
      wb_ack = 1'b0;
      tick(2);
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      #1 rst_n = 1'b0;          // R1
      tick(4);
      rst_n = 1'b1;
      tick(2);
      hold_grant = 1'b1;

      // R9: core fills of both caches, inquiry sees them (R3, R4, R11)
      fill(1, 100, 5, 0, 2);    // data E
      fill(1, 200, 5, 1, 3);    // data M, way 1
      fill(0, 100, 5, 1, 1);    // instruction valid, way 1
      fill(1, 300, 9, 1, 1);    // data S
      inquire(100, 5, 0, 7);    // clean; E -> S (R6), offset ignored (R11)
      inquire(200, 5, 0);       // modified; M -> S (R6)
      inquire(200, 5, 0, 31);   // now clean
      inquire(300, 9, 0);       // shared stays shared
      inquire(999, 5, 0);       // miss

      // R2: strobe without grant has no effect
      hold_grant = 1'b0;
      inquire(999, 9, 1);
      inquire(300, 9, 1);
      hold_grant = 1'b1;
      inquire(300, 9, 0);       // still present

      // R7: invalidating modified hit, writeback handshake; R8 busy strobe
      fill(1, 400, 7, 0, 3);
      inquire(400, 7, 1);
      inquire(300, 9, 0);       // rejected while wb_req high (R8)
      ack_wb(3);
      inquire(400, 7, 0);       // gone after acknowledge

      // R7: invalidation of clean lines in both caches
      inquire(100, 5, 1);
      inquire(100, 5, 0);

      // R8: back-to-back strobe during lookup cycle
      inq_strobe = 1'b1; inq_inval = 1'b0; inq_addr = mk(300, 9);
      tick(2);
      inq_strobe = 1'b0;
      tick(3);

      // R10: core write to the same line at the lookup edge
      fill(1, 500, 12, 1, 1);
      inq_strobe = 1'b1; inq_inval = 1'b1; inq_addr = mk(500, 12);
      tick();
      inq_strobe = 1'b0;
      core_wr_en = 1'b1; core_wr_dc = 1'b1; core_wr_addr = mk(600, 12);
      core_wr_way = 1'b1; core_wr_state = 2'd3;
      tick();
      core_wr_en = 1'b0;
      tick(3);
      inquire(600, 12, 0);      // snoop won: no hit

      // R10: core write to the same line at the acknowledge edge
      fill(1, 700, 20, 0, 3);
      inquire(700, 20, 1);
      tick(2);
      wb_ack = 1'b1;
      core_wr_en = 1'b1; core_wr_dc = 1'b1; core_wr_addr = mk(800, 20);
      core_wr_way = 1'b0; core_wr_state = 2'd2;
      tick();
      wb_ack = 1'b0; core_wr_en = 1'b0;
      tick(2);
      inquire(800, 20, 0);

      // Randomized traffic over a small tag/set space (all requirements)
      for (int i = 0; i < 4000; i++) begin
         hold_grant    = ($urandom % 8) != 0;
         inq_strobe    = ($urandom % 4) == 0;
         inq_inval     = $urandom % 2;
         inq_addr      = mk(($urandom % 3) + 1, $urandom % 3, $urandom % 32);
         wb_ack        = ($urandom % 3) == 0;
         core_wr_en    = ($urandom % 3) == 0;
         core_wr_dc    = $urandom % 2;
         core_wr_addr  = mk(($urandom % 3) + 1, $urandom % 3);
         core_wr_way   = 1'($urandom % 2);
         core_wr_state = 2'($urandom % 4);
         tick();
      end
      inq_strobe = 1'b0; core_wr_en = 1'b0; wb_ack = 1'b1;
      tick(4);
      finish_run();
   end

endmodule